// File: doc/BRIEF.md
# Memory-Space Bus Target Engine

This block is the slave side of a 32-bit parallel multiplexed bus with active-low control. During the address clock it reads the command off the shared command/byte-enable lines and takes the address off the address/data lines. It claims only memory reads and memory writes whose address falls inside a power-of-two window at a fixed base. The block then carries the transaction one data phase at a time. Each phase turns into a single-word request on a simple register-file port behind it. A word crosses the bus only on a clock edge where both sides signal ready.

Read data comes from a register, and even parity over that word and the byte-enable lines follows one clock behind it. If the back end leaves a request unanswered for too long, the engine signals stop and waits for the initiator to release the bus. Bursts move through the window one word at a time and wrap at its end. Commands that are not claimed, and addresses outside the window, leave every driven output inactive until the bus goes idle.

Top module: `pcitgt_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `devsel_n`, `trdy_n` and `stop_n` are high and `ctl_oe`, `ad_oe`, `par_oe` and `be_req` are low.
- R2: In an idle cycle with `frame_n` low, the engine claims the cycle if `cbe_n_in` is 4'b0110 (memory read) or 4'b0111 (memory write) and `ad_in[31:WIN_BITS]` equals the window base. From the next cycle `devsel_n` is low and `ctl_oe` is high until the transaction ends.
- R3: An address phase with any other command, or with an address outside the window, is ignored. `devsel_n`, `trdy_n` and `stop_n` stay high and `ctl_oe`, `ad_oe` and `be_req` stay low until a cycle in which `frame_n` and `irdy_n` are both high.
- R4: In a claimed data phase before the target side is ready, `be_req` is high. For a read it is high at once; for a write only while `irdy_n` is low. It carries `be_we` (1 for a write), `be_addr` = the window byte offset with bits [1:0] zero, `be_ben` = `~cbe_n_in` (bit i enables byte lane i), and `be_wdata` = `ad_in`.
- R5: `trdy_n` goes low in the cycle after `be_ready` is sampled high with `be_req`. For a read, `ad_out` then holds the `be_rdata` captured at that edge, and `ad_oe` is high for every cycle of a claimed read transaction.
- R6: A data phase completes on a clock edge where `trdy_n` and `irdy_n` are both low. Any other cycle is a wait state and the phase repeats.
- R7: Each completed phase that is not the last adds 4 to the offset, wrapping modulo the window size.
- R8: A phase that completes with `frame_n` high is the last one. `devsel_n` returns high in the next cycle.
- R9: `par_oe` is high exactly in the cycles after one in which `ad_oe` was high. In those cycles `par_out` equals the XOR of the previous cycle's `ad_out` and `cbe_n_in`, which is even parity over 36 bits.
- R10: When a request stays unanswered for `WAIT_LIMIT` (default 8) request cycles in one phase, `stop_n` goes low from the next cycle, with `devsel_n` low and `trdy_n` high. It stays low until a cycle with `frame_n` and `irdy_n` both high, after which the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Transaction frame from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | 32 | Address/data lines as seen on the bus |
| cbe_n_in | input | 4 | Command during the address phase, active-low byte enables afterwards |
| ad_out | output | 32 | Read data driven toward the bus |
| ad_oe | output | 1 | Output enable for `ad_out` |
| par_out | output | 1 | Even parity, one clock behind the read data |
| par_oe | output | 1 | Output enable for `par_out` |
| devsel_n | output | 1 | Device-select claim, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop request, active low |
| ctl_oe | output | 1 | Output enable for devsel/trdy/stop |
| be_req | output | 1 | Back-end request |
| be_we | output | 1 | Request is a write |
| be_addr | output | WIN_BITS | Byte offset inside the window |
| be_ben | output | 4 | Active-high byte enables |
| be_wdata | output | 32 | Write data |
| be_rdata | input | 32 | Read data from the back end |
| be_ready | input | 1 | Back end completes the request this cycle |

## Verification
The back-end request fields are combinational and are due in the same cycle as the stimulus that raises them. `devsel_n` is due one clock after the address phase, `trdy_n` and the read word one clock after `be_ready`, parity one clock after the read word, and `stop_n` one clock after the last unanswered request cycle. The bench drives inputs at the falling edge and answers as the back end a nanosecond later. It compares every output with its own model shortly before the rising edge, so each result is checked in the cycle it is due, and only then steps the model. Scenarios include wait states on both sides, partial byte enables, a burst that wraps the window, ignored commands and stops on both a read and a write.

// File: rtl/pcitgt_pkg.sv
package pcitgt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_STOP = 2'd2,
        ST_SKIP = 2'd3
    } tgt_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

    typedef struct packed {
        logic hit;
        logic write;
    } claim_t;

    typedef struct packed {
        tgt_state_e st;
        logic       rdy;
        logic       wr;
    } seq_view_t;

    function automatic logic even_par36(input logic [31:0] d, input logic [3:0] c);
        return ^{d, c};
    endfunction

    function automatic logic is_mem_cmd(input logic [3:0] c);
        return (c == CMD_MEM_RD) || (c == CMD_MEM_WR);
    endfunction

endpackage

// File: rtl/pcitgt_decode.sv
module pcitgt_decode
    import pcitgt_pkg::*;
#(
    parameter logic [31:0] BAR_BASE = 32'h4000_0000,
    parameter int          WIN_BITS = 12
) (
    input  logic [31:WIN_BITS] tag,
    input  logic [3:0]         cmd,
    output claim_t             claim
);
    localparam logic [31:WIN_BITS] BASE_TAG = BAR_BASE[31:WIN_BITS];

    always_comb begin
        claim.hit   = is_mem_cmd(cmd) && (tag == BASE_TAG);
        claim.write = cmd[0];
    end
endmodule

// File: rtl/pcitgt_seq.sv
module pcitgt_seq
    import pcitgt_pkg::*;
#(
    parameter int WIN_BITS   = 12,
    parameter int WAIT_LIMIT = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_n,
    input  logic                  irdy_n,
    input  logic [WIN_BITS-1:2]   start_word,
    input  claim_t                claim,
    input  logic                  be_ready,
    input  logic [31:0]           be_rdata,
    output seq_view_t             view,
    output logic [WIN_BITS-3:0]   word,
    output logic [31:0]           rdata,
    output logic                  be_req
);
    localparam int WORD_W = WIN_BITS - 2;
    localparam int CNT_W  = $clog2(WAIT_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_LIMIT - 1);

    tgt_state_e          state_q;
    logic                rdy_q;
    logic                write_q;
    logic [WORD_W-1:0]   word_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [31:0]         rdata_q;
    logic                xfer;
    logic                bus_idle;

    always_comb begin
        be_req   = (state_q == ST_DATA) && !rdy_q && (!write_q || !irdy_n);
        xfer     = (state_q == ST_DATA) && rdy_q && !irdy_n;
        bus_idle = frame_n && irdy_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rdy_q   <= 1'b0;
            write_q <= 1'b0;
            word_q  <= '0;
            cnt_q   <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (!frame_n) begin
                        if (claim.hit) begin
                            state_q <= ST_DATA;
                            write_q <= claim.write;
                            word_q  <= start_word;
                            rdy_q   <= 1'b0;
                            cnt_q   <= '0;
                        end else begin
                            state_q <= ST_SKIP;
                        end
                    end
                end
                ST_DATA: begin
                    if (xfer) begin
                        rdy_q <= 1'b0;
                        cnt_q <= '0;
                        if (frame_n) state_q <= ST_IDLE;
                        else         word_q  <= word_q + WORD_W'(1);
                    end else if (be_req) begin
                        if (be_ready) begin
                            rdy_q <= 1'b1;
                            cnt_q <= '0;
                            if (!write_q) rdata_q <= be_rdata;
                        end else if (cnt_q == CNT_LAST) begin
                            state_q <= ST_STOP;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    if (bus_idle) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        view.st  = state_q;
        view.rdy = rdy_q;
        view.wr  = write_q;
        word     = word_q;
        rdata    = rdata_q;
    end
endmodule

// File: rtl/pcitgt_parity.sv
module pcitgt_parity
    import pcitgt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] data,
    input  logic [3:0]  lanes,
    input  logic        drive,
    output logic        par_out,
    output logic        par_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_out <= even_par36(data, lanes);
            par_oe  <= drive;
        end
    end
endmodule

// File: rtl/pcitgt_engine.sv
module pcitgt_engine
    import pcitgt_pkg::*;
#(
    parameter logic [31:0] BAR_BASE   = 32'h4000_0000,
    parameter int          WIN_BITS   = 12,
    parameter int          WAIT_LIMIT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_n,
    input  logic                irdy_n,
    input  logic [31:0]         ad_in,
    input  logic [3:0]          cbe_n_in,
    output logic [31:0]         ad_out,
    output logic                ad_oe,
    output logic                par_out,
    output logic                par_oe,
    output logic                devsel_n,
    output logic                trdy_n,
    output logic                stop_n,
    output logic                ctl_oe,
    output logic                be_req,
    output logic                be_we,
    output logic [WIN_BITS-1:0] be_addr,
    output logic [3:0]          be_ben,
    output logic [31:0]         be_wdata,
    input  logic [31:0]         be_rdata,
    input  logic                be_ready
);
    claim_t              claim;
    seq_view_t           view;
    logic [WIN_BITS-3:0] word;
    logic [31:0]         rdata;
    logic                in_data;
    logic                claimed;

    pcitgt_decode #(.BAR_BASE(BAR_BASE), .WIN_BITS(WIN_BITS)) u_dec (
        .tag   (ad_in[31:WIN_BITS]),
        .cmd   (cbe_n_in),
        .claim (claim)
    );

    pcitgt_seq #(.WIN_BITS(WIN_BITS), .WAIT_LIMIT(WAIT_LIMIT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .start_word (ad_in[WIN_BITS-1:2]),
        .claim      (claim),
        .be_ready   (be_ready),
        .be_rdata   (be_rdata),
        .view       (view),
        .word       (word),
        .rdata      (rdata),
        .be_req     (be_req)
    );

    always_comb begin
        in_data  = (view.st == ST_DATA);
        claimed  = in_data || (view.st == ST_STOP);
        devsel_n = !claimed;
        ctl_oe   = claimed;
        trdy_n   = !(in_data && view.rdy);
        stop_n   = !(view.st == ST_STOP);
        ad_oe    = in_data && !view.wr;
        ad_out   = rdata;
        be_we    = view.wr;
        be_addr  = {word, 2'b00};
        be_ben   = ~cbe_n_in;
        be_wdata = ad_in;
    end

    pcitgt_parity u_par (
        .clk     (clk),
        .rst     (rst),
        .data    (ad_out),
        .lanes   (cbe_n_in),
        .drive   (ad_oe),
        .par_out (par_out),
        .par_oe  (par_oe)
    );
endmodule

// File: rtl/pcitgt_engine_chk.sv
module pcitgt_engine_chk
    import pcitgt_pkg::*;
#(
    parameter int WAIT_LIMIT = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        frame_n,
    input logic        irdy_n,
    input logic [3:0]  cbe_n_in,
    input logic [31:0] ad_out,
    input logic        ad_oe,
    input logic        par_out,
    input logic        par_oe,
    input logic        devsel_n,
    input logic        trdy_n,
    input logic        stop_n,
    input logic        be_req,
    input logic        be_we,
    input logic        be_ready
);
    localparam int CW = $clog2(WAIT_LIMIT + 2);
    logic [CW-1:0] miss_run;

    always_ff @(posedge clk) begin
        if (rst)                     miss_run <= '0;
        else if (be_req && !be_ready) miss_run <= miss_run + CW'(1);
        else                          miss_run <= '0;
    end

    assert_trdy_claimed_R5: assert property (@(posedge clk) disable iff (rst)
        !trdy_n |-> !devsel_n);

    assert_stop_no_data_R10: assert property (@(posedge clk) disable iff (rst)
        !stop_n |-> (trdy_n && !devsel_n));

    assert_stop_after_miss_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_n) |-> $past(be_req && !be_ready));

    assert_wait_bound_R10: assert property (@(posedge clk) disable iff (rst)
        miss_run <= CW'(WAIT_LIMIT));

    assert_par_oe_follows_R9: assert property (@(posedge clk) disable iff (rst)
        par_oe == $past(ad_oe));

    assert_par_value_R9: assert property (@(posedge clk) disable iff (rst)
        par_oe |-> (par_out == ^{$past(ad_out), $past(cbe_n_in)}));

    assert_wr_req_irdy_R4: assert property (@(posedge clk) disable iff (rst)
        (be_req && be_we) |-> !irdy_n);

    assert_claim_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n) |-> $past(is_mem_cmd(cbe_n_in) && !frame_n));

    assert_last_release_R8: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n && !irdy_n && frame_n) |=> devsel_n);
endmodule

bind pcitgt_engine pcitgt_engine_chk #(.WAIT_LIMIT(WAIT_LIMIT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .cbe_n_in (cbe_n_in),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .par_out  (par_out),
    .par_oe   (par_oe),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .stop_n   (stop_n),
    .be_req   (be_req),
    .be_we    (be_we),
    .be_ready (be_ready)
);

// File: tb/pcitgt_engine_bench.sv
module pcitgt_engine_bench;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam int WIN = 12;
    localparam int NW  = 1 << (WIN - 2);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, frame_n, irdy_n, be_ready;
    logic [31:0] ad_in, be_rdata;
    logic [3:0]  cbe_n_in;
    logic [31:0] ad_out, be_wdata;
    logic ad_oe, par_out, par_oe, devsel_n, trdy_n, stop_n, ctl_oe, be_req, be_we;
    logic [WIN-1:0] be_addr;
    logic [3:0] be_ben;

    pcitgt_engine #(.BAR_BASE(BASE), .WIN_BITS(WIN), .WAIT_LIMIT(8)) u_pcitgt_engine (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in),
        .cbe_n_in(cbe_n_in), .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out),
        .par_oe(par_oe), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .ctl_oe(ctl_oe), .be_req(be_req), .be_we(be_we), .be_addr(be_addr),
        .be_ben(be_ben), .be_wdata(be_wdata), .be_rdata(be_rdata), .be_ready(be_ready)
    );

    logic [31:0] mem [NW];
    int checks = 0, errors = 0, cycles = 0, lat = 0, bwait = 0;

    // reference model: 0 idle, 1 data, 2 stop, 3 skip
    int ms = 0, mword = 0, mc = 0;
    bit mr = 0, mw = 0, mp = 0, mpoe = 0;
    logic [31:0] md = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic [31:0] wpat(input int w, input int i);
        return 32'(32'h3C00_0000 + w * 32'h0001_0011 + i * 32'h0100_0000);
    endfunction

    // one bus cycle: called right after a falling edge with inputs set
    task automatic tick();
        bit e_dev, e_trdy, e_stop, e_oe, e_req, brdy, hit, xfer, npar;
        #1;
        if (be_req === 1'b1 && bwait >= lat) begin
            be_ready = 1'b1;
            be_rdata = be_we ? 32'h0 : mem[be_addr[WIN-1:2]];
        end else begin
            be_ready = 1'b0;
            be_rdata = 32'hDEAD_BEEF;
        end
        #1;
        e_dev  = !(ms == 1 || ms == 2);
        e_trdy = !(ms == 1 && mr);
        e_stop = (ms != 2);
        e_oe   = (ms == 1) && !mw;
        e_req  = (ms == 1) && !mr && (!mw || !irdy_n);
        chk(devsel_n === e_dev, "R2 R8", "devsel_n", devsel_n, e_dev);
        chk(ctl_oe === !e_dev, "R2", "ctl_oe", ctl_oe, !e_dev);
        chk(trdy_n === e_trdy, "R5 R6", "trdy_n", trdy_n, e_trdy);
        chk(stop_n === e_stop, "R10", "stop_n", stop_n, e_stop);
        chk(ad_oe === e_oe, "R5", "ad_oe", ad_oe, e_oe);
        if (e_oe) chk(ad_out === md, "R5", "ad_out", ad_out, md);
        chk(par_oe === mpoe, "R9", "par_oe", par_oe, mpoe);
        if (mpoe) chk(par_out === mp, "R9", "par_out", par_out, mp);
        chk(be_req === e_req, "R4 R3", "be_req", be_req, e_req);
        if (e_req) begin
            chk(be_we === mw, "R4", "be_we", be_we, mw);
            chk(be_addr === WIN'(mword * 4), "R4 R7", "be_addr", be_addr, mword * 4);
            chk(be_ben === ~cbe_n_in, "R4", "be_ben", be_ben, ~cbe_n_in);
            if (mw) chk(be_wdata === ad_in, "R4", "be_wdata", be_wdata, ad_in);
        end
        // model step
        brdy = e_req && (bwait >= lat);
        npar = ^{md, cbe_n_in};
        case (ms)
            0: if (!frame_n) begin
                hit = (cbe_n_in == 4'b0110 || cbe_n_in == 4'b0111) && (ad_in[31:WIN] == BASE[31:WIN]);
                if (hit) begin
                    ms = 1; mw = cbe_n_in[0]; mword = int'(ad_in[WIN-1:2]); mr = 0; mc = 0;
                end else ms = 3;
            end
            1: begin
                xfer = mr && !irdy_n;
                if (xfer) begin
                    mr = 0; mc = 0;
                    if (frame_n) ms = 0;
                    else mword = (mword + 1) % NW;
                end else if (e_req) begin
                    if (brdy) begin
                        mr = 1; mc = 0;
                        if (!mw) md = mem[mword];
                    end else if (mc == 7) begin
                        ms = 2; mc = 0;
                    end else mc++;
                end
            end
            default: if (frame_n && irdy_n) ms = 0;
        endcase
        mp = npar;
        mpoe = e_oe;
        // back end
        if (be_ready && be_we)
            for (int b = 0; b < 4; b++)
                if (be_ben[b]) mem[be_addr[WIN-1:2]][8*b +: 8] = be_wdata[8*b +: 8];
        bwait = (be_req === 1'b1 && !be_ready) ? bwait + 1 : 0;
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "R6", "watchdog expired", cycles, 150000);
            summary();
        end
        @(negedge clk);
    endtask

    task automatic bus_idle(input int n);
        for (int k = 0; k < n; k++) begin
            frame_n = 1; irdy_n = 1; ad_in = 0; cbe_n_in = 4'hF;
            tick();
        end
    endtask

    task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                        input int gap, input logic [3:0] ben, output bit stopped);
        int idx, done;
        idx = int'(addr[WIN-1:2]);
        done = 0;
        stopped = 0;
        frame_n = 0; irdy_n = 1; ad_in = addr; cbe_n_in = cmd;
        tick();
        for (int i = 0; i < n && !stopped; i++) begin
            int w;
            logic [31:0] wd;
            w = (idx + i) % NW;
            wd = wpat(w, i);
            for (int g = 0; g < gap; g++) begin
                frame_n = 0; irdy_n = 1; cbe_n_in = ~ben; ad_in = cmd[0] ? wd : 32'h0;
                tick();
            end
            frame_n = (i == n - 1); irdy_n = 0; cbe_n_in = ~ben; ad_in = cmd[0] ? wd : 32'h0;
            for (int k = 0; ; k++) begin
                logic tr, st;
                tr = trdy_n;
                st = stop_n;
                if (!tr && !cmd[0]) chk(ad_out === mem[w], "R5 R7", "read word on bus", ad_out, mem[w]);
                tick();
                if (!tr) begin done++; break; end
                if (!st) begin stopped = 1; break; end
                if (k > 200) begin chk(1'b0, "R6", "phase never completed", k, 0); stopped = 1; break; end
            end
        end
        if (stopped) begin
            frame_n = 1; irdy_n = 0;
            tick();
        end else begin
            chk(devsel_n === 1'b1, "R8", "devsel_n after last phase", devsel_n, 1);
            chk(done == n, "R6", "words transferred", done, n);
        end
        bus_idle(1);
    endtask

    task automatic ignored(input logic [3:0] cmd, input logic [31:0] addr);
        frame_n = 0; irdy_n = 1; ad_in = addr; cbe_n_in = cmd;
        tick();
        for (int k = 0; k < 3; k++) begin
            frame_n = (k == 2); irdy_n = 0; ad_in = 32'h1234_5678; cbe_n_in = 4'h0;
            chk(devsel_n === 1'b1 && ctl_oe === 1'b0, "R3", "ignored cycle claimed", devsel_n, 1);
            chk(be_req === 1'b0 && ad_oe === 1'b0, "R3", "ignored cycle drove", {be_req, ad_oe}, 0);
            tick();
        end
        bus_idle(1);
    endtask

    bit stp;
    logic [31:0] keep;

    initial begin
        for (int i = 0; i < NW; i++) mem[i] = 32'h5A5A_0000 ^ 32'(i * 32'h0001_0003);
        rst = 1; frame_n = 1; irdy_n = 1; ad_in = 0; cbe_n_in = 4'hF;
        be_ready = 0; be_rdata = 0;
        repeat (3) @(negedge clk);
        chk(devsel_n === 1 && trdy_n === 1 && stop_n === 1, "R1", "control lines in reset",
            {devsel_n, trdy_n, stop_n}, 3'b111);
        chk(ad_oe === 0 && par_oe === 0 && ctl_oe === 0 && be_req === 0, "R1", "enables in reset",
            {ad_oe, par_oe, ctl_oe, be_req}, 0);
        rst = 0;
        chk(devsel_n === 1 && trdy_n === 1 && stop_n === 1 && ad_oe === 0, "R1",
            "idle after reset", {devsel_n, trdy_n, stop_n, ad_oe}, 4'b1110);
        bus_idle(2);

        // R4 R6: write burst, immediate back end
        lat = 0; xact(4'b0111, BASE + 32'h10, 4, 0, 4'hF, stp);
        // R5 R7 R9: read back with target and initiator wait states
        lat = 2; xact(4'b0110, BASE + 32'h10, 4, 1, 4'hF, stp);
        lat = 0; xact(4'b0110, BASE + 32'h14, 3, 0, 4'b0011, stp);
        // R4: partial byte enables
        keep = mem[40];
        lat = 1; xact(4'b0111, BASE + 32'hA0, 1, 2, 4'b0101, stp);
        chk(mem[40] === ((keep & 32'hFF00_FF00) | (wpat(40, 0) & 32'h00FF_00FF)), "R4",
            "byte-lane merge", mem[40], (keep & 32'hFF00_FF00) | (wpat(40, 0) & 32'h00FF_00FF));
        xact(4'b0110, BASE + 32'hA0, 1, 0, 4'hF, stp);
        // R7: burst wraps the window
        lat = 0; xact(4'b0111, BASE + 32'hFF8, 3, 0, 4'hF, stp);
        chk(mem[0] === wpat(0, 2), "R7", "wrapped word", mem[0], wpat(0, 2));
        xact(4'b0110, BASE + 32'hFF8, 3, 1, 4'hF, stp);
        // R3: unclaimed command and foreign address
        keep = mem[4];
        ignored(4'b0010, BASE + 32'h10);
        ignored(4'b0111, 32'h8000_0010);
        ignored(4'b0110, BASE + 32'h1000);
        chk(mem[4] === keep, "R3", "ignored write left memory", mem[4], keep);
        // R10: stalled back end on read and on write
        lat = 20; xact(4'b0110, BASE + 32'h40, 2, 0, 4'hF, stp);
        chk(stp == 1'b1, "R10", "read stopped", stp, 1);
        chk(devsel_n === 1 && stop_n === 1, "R10", "released after stop", {devsel_n, stop_n}, 2'b11);
        keep = mem[20];
        xact(4'b0111, BASE + 32'h50, 2, 0, 4'hF, stp);
        chk(stp == 1'b1, "R10", "write stopped", stp, 1);
        chk(mem[20] === keep, "R10", "stopped write not stored", mem[20], keep);
        // R10: a seven-cycle back end still completes
        lat = 7; xact(4'b0110, BASE + 32'h60, 2, 0, 4'hF, stp);
        chk(stp == 1'b0, "R10", "no stop inside limit", stp, 0);
        lat = 0; xact(4'b0110, BASE + 32'h10, 2, 0, 4'hF, stp);
        bus_idle(3);
        summary();
    end
endmodule